// File: doc/BRIEF.md
# Receive Packet Header and Payload Splitter

This block sits on the receive side of a transaction layer. Packets arrive on a 256-bit streaming bus, eight dwords per beat, with at most one packet in any beat. Every packet begins in the low half of its first beat, and its 3- or 4-dword header fills the bottom lanes. The lane where the payload starts depends on the header size and on address bit 2, so there may be a pad dword before the first payload dword. There may also be a pad dword after the last one.

The splitter takes the header off the first beat and presents it on a sideband port for one cycle, together with its decoded format and length fields. It drops the pad dwords and re-packs the payload into a second 256-bit stream in which payload dword 0 is always in lane 0. Up to seven dwords carry over between beats in a residue register. When those leftover dwords outlive the input packet, the block issues one extra flush beat. The output stream has its own handshake and a count of valid dwords on each beat. Backpressure from the output reaches the input ready without losing or repeating any dword.

Top module: `rx_tlp_splitter`

## Requirements
- R1: An input beat is taken only on a cycle with inValid and inReady both high. An output beat is consumed only on a cycle with outValid and outReady both high.
- R2: One cycle after a start beat is taken, hdrValid pulses for exactly one cycle with the following values:
  - hdrData holds input bits [127:0].
  - hdrFourDw is bit 29 of dword 0.
  - hdrHasData is bit 30 of dword 0.
  - hdrLength is bits [9:0] of dword 0, where a value of 0 stands for 1024 dwords.
- R3: For a 3-dword header, address bit 2 is bit 2 of dword 2. When that bit is 0, payload dword 0 is taken from lane 4; otherwise it is taken from lane 3.
- R4: For a 4-dword header, address bit 2 is bit 2 of dword 3. When that bit is 0, payload dword 0 is taken from lane 4; otherwise it is taken from lane 5.
- R5: Payload dword k of a packet appears in output beat k/8, lane k%8 (bits [32*(k%8)+31 : 32*(k%8)]). outSop is high on the first output beat of each packet and low on all later beats.
- R6: outEop marks the beat that carries the last payload dword. On that beat outCount is the number of valid dwords, from 1 to 8; on every other beat outCount is 8.
- R7: Payload continues lane by lane into the following beats. On the end beat, inEmpty gives the number of unused qwords at the top of the bus: 1 leaves bits [191:0] valid and 2 leaves bits [127:0] valid. inEmpty is ignored on other beats, and dwords past the header length are discarded.
- R8: If leftover dwords remain after the input end beat has been consumed, they are sent as one extra beat with outEop set. While that beat is pending, inReady is low.
- R9: While outValid is high and outReady is low, outData, outCount, outSop and outEop hold their values. No payload dword is lost or duplicated under any output backpressure.
- R10: A packet whose hdrHasData bit is 0 produces its header strobe and no output data beat.
- R11: After reset, outValid and hdrValid are low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 256 | Input beat, eight dwords |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Block can take an input beat |
| inSop | input | 1 | First beat of a packet |
| inEop | input | 1 | Last beat of a packet |
| inEmpty | input | 2 | Unused qwords on the end beat |
| outData | output | 256 | Re-packed payload, dword 0 in lane 0 |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Consumer takes the output beat |
| outSop | output | 1 | First payload beat of a packet |
| outEop | output | 1 | Last payload beat of a packet |
| outCount | output | 4 | Valid dwords in the output beat |
| hdrValid | output | 1 | One-cycle header strobe |
| hdrData | output | 128 | Header dwords 0 to 3 |
| hdrFourDw | output | 1 | Header is 4 dwords long |
| hdrHasData | output | 1 | Packet carries payload |
| hdrLength | output | 10 | Payload length field in dwords |

## Verification
The bench covers all four combinations of header size and address bit 2, and it makes the wrong header dword's address bit disagree with the right one. A design that picks the offset from the wrong dword, or that drops or keeps the wrong pad dword, then puts shifted or pad data into lane 0. Payload lengths are chosen so that the residue exactly fills a beat, overflows into a flush beat, or leaves a trailing pad dword. A design that mis-counts these cases shows a wrong outCount, a missing or doubled end beat, or an extra beat of pad data. Random output backpressure and input idle gaps make a design that overwrites the holding register lose or repeat dwords. Packets without payload, and a length field of 0 meaning 1024 dwords, expose a design that sends a stray empty beat or cuts the length short.

// File: rtl/rx_split_pkg.sv
package rx_split_pkg;
  localparam int DWW   = 32;
  localparam int LANES = 8;
  localparam int BUSW  = DWW * LANES;
  localparam int LANEW = $clog2(LANES);
  localparam int CNTW  = $clog2(LANES + 1);
  localparam int TOTW  = CNTW + 1;
  localparam int LENW  = 10;
  localparam int REMW  = LENW + 1;
  localparam int EMPW  = 2;
  localparam int HDRW  = 4 * DWW;
  localparam int FMT4_BIT = 29;
  localparam int FMTD_BIT = 30;
  localparam int ADDR_BIT = 2;

  typedef struct packed {
    logic            fourDw;
    logic            hasData;
    logic [LENW-1:0] len;
    logic            addrBit2;
  } hdrFieldsT;

  typedef struct packed {
    logic             accept;
    logic             sopBeat;
    logic [LANEW-1:0] skip;
    logic [CNTW-1:0]  take;
    logic [LANEW-1:0] resLvl;
    logic             load;
    logic             upperToRes;
    logic             flush;
  } ctrlT;
endpackage

// File: rtl/rx_split_ctrl.sv
module rx_split_ctrl
  import rx_split_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inSop,
  input  logic            inEop,
  input  logic [EMPW-1:0] inEmpty,
  input  hdrFieldsT       hdrF,
  input  logic            outReady,
  output logic            inReady,
  output logic            outValid,
  output logic            outSop,
  output logic            outEop,
  output logic [CNTW-1:0] outCount,
  output ctrlT            ctrl
);
  logic [LANEW-1:0] resQ;
  logic             flushQ;
  logic [REMW-1:0]  remQ;
  logic             pktDataQ;
  logic             sopPendQ;

  logic             slotFree, accept, flushGo, hasD, done, sopPend;
  logic [CNTW-1:0]  beatDw, avail, take, loadCnt;
  logic [LANEW-1:0] skip, newRes;
  logic [REMW-1:0]  remIn, remAfter;
  logic [TOTW-1:0]  total;
  logic             loadC, loadEop, newFlush, upperToRes;

  always_comb begin
    slotFree = !outValid || outReady;
    inReady  = slotFree && !flushQ;
    accept   = inValid && inReady;
    flushGo  = flushQ && slotFree;

    beatDw = inEop ? CNTW'(LANES - 2 * int'(inEmpty)) : CNTW'(LANES);
    if (!inSop)            skip = '0;
    else if (hdrF.fourDw)  skip = hdrF.addrBit2 ? LANEW'(5) : LANEW'(4);
    else                   skip = hdrF.addrBit2 ? LANEW'(3) : LANEW'(4);
    avail = (beatDw > CNTW'(skip)) ? beatDw - CNTW'(skip) : '0;

    hasD     = inSop ? hdrF.hasData : pktDataQ;
    remIn    = inSop ? {(hdrF.len == '0), hdrF.len} : remQ;
    take     = !hasD ? '0 : ((remIn < REMW'(avail)) ? CNTW'(remIn) : avail);
    remAfter = remIn - REMW'(take);
    done     = hasD && ((remAfter == '0) || inEop);
    total    = TOTW'(resQ) + TOTW'(take);
    sopPend  = inSop ? hdrF.hasData : sopPendQ;

    loadC      = 1'b0;
    loadEop    = 1'b0;
    loadCnt    = '0;
    newFlush   = 1'b0;
    upperToRes = 1'b0;
    newRes     = LANEW'(total);
    if (total >= TOTW'(LANES)) begin
      loadC      = 1'b1;
      upperToRes = 1'b1;
      loadCnt    = CNTW'(LANES);
      newRes     = LANEW'(total - TOTW'(LANES));
      loadEop    = done && (total == TOTW'(LANES));
      newFlush   = done && (total > TOTW'(LANES));
    end else if (done && (total != '0)) begin
      loadC   = 1'b1;
      loadCnt = CNTW'(total);
      loadEop = 1'b1;
      newRes  = '0;
    end

    ctrl.accept     = accept;
    ctrl.sopBeat    = inSop;
    ctrl.skip       = skip;
    ctrl.take       = take;
    ctrl.resLvl     = resQ;
    ctrl.load       = accept && loadC;
    ctrl.upperToRes = upperToRes;
    ctrl.flush      = flushGo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ     <= '0;
      flushQ   <= 1'b0;
      remQ     <= '0;
      pktDataQ <= 1'b0;
      sopPendQ <= 1'b0;
    end else if (accept) begin
      resQ     <= newRes;
      flushQ   <= newFlush;
      remQ     <= remAfter;
      pktDataQ <= hasD && !done;
      sopPendQ <= (loadC || done) ? 1'b0 : sopPend;
    end else if (flushGo) begin
      resQ   <= '0;
      flushQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outCount <= '0;
    end else if (accept && loadC) begin
      outValid <= 1'b1;
      outSop   <= sopPend;
      outEop   <= loadEop;
      outCount <= loadCnt;
    end else if (flushGo) begin
      outValid <= 1'b1;
      outSop   <= 1'b0;
      outEop   <= 1'b1;
      outCount <= CNTW'(resQ);
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  a_r9_hold_ctl: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable({outCount, outSop, outEop}));
  a_r6_count_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCount != '0) && (outCount <= CNTW'(LANES)));
  a_r6_full_mid: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outEop |-> outCount == CNTW'(LANES));
  a_r5_clean_start: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && inSop |-> (resQ == '0) && !flushQ);
endmodule

// File: rtl/rx_split_datapath.sv
module rx_split_datapath
  import rx_split_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [BUSW-1:0] inData,
  input  ctrlT            ctrl,
  input  logic            outValid,
  input  logic            outReady,
  output hdrFieldsT       hdrF,
  output logic [BUSW-1:0] outData,
  output logic            hdrValid,
  output logic [HDRW-1:0] hdrData,
  output logic            hdrFourDw,
  output logic            hdrHasData,
  output logic [LENW-1:0] hdrLength
);
  logic [LANES-1:0][DWW-1:0]   resData;
  logic [LANES-1:0][DWW-1:0]   newArr;
  logic [2*LANES-1:0][DWW-1:0] merged;

  always_comb begin
    hdrF.fourDw   = inData[FMT4_BIT];
    hdrF.hasData  = inData[FMTD_BIT];
    hdrF.len      = inData[LENW-1:0];
    hdrF.addrBit2 = inData[FMT4_BIT] ? inData[3*DWW+ADDR_BIT] : inData[2*DWW+ADDR_BIT];
  end

  assign newArr = inData >> (DWW * int'(ctrl.skip));

  for (genvar g = 0; g < 2 * LANES; g++) begin : gLane
    logic [LANEW+1:0] idx;
    logic [DWW-1:0]   fresh;
    assign idx   = (LANEW+2)'(g) - (LANEW+2)'(ctrl.resLvl);
    assign fresh = (idx < (LANEW+2)'(ctrl.take)) ? newArr[idx[LANEW-1:0]] : '0;
    if (g < LANES) begin : gLow
      assign merged[g] = ((LANEW+2)'(g) < (LANEW+2)'(ctrl.resLvl)) ? resData[g] : fresh;
    end else begin : gHigh
      assign merged[g] = fresh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      outData <= '0;
    end else begin
      if (ctrl.accept)
        resData <= ctrl.upperToRes ? merged[2*LANES-1:LANES] : merged[LANES-1:0];
      if (ctrl.flush)
        outData <= resData;
      else if (ctrl.load)
        outData <= merged[LANES-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrValid   <= 1'b0;
      hdrData    <= '0;
      hdrFourDw  <= 1'b0;
      hdrHasData <= 1'b0;
      hdrLength  <= '0;
    end else begin
      hdrValid <= ctrl.accept && ctrl.sopBeat;
      if (ctrl.accept && ctrl.sopBeat) begin
        hdrData    <= inData[HDRW-1:0];
        hdrFourDw  <= hdrF.fourDw;
        hdrHasData <= hdrF.hasData;
        hdrLength  <= hdrF.len;
      end
    end
  end

  a_r9_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData));
  a_r2_hdr_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && !ctrl.accept |=> !hdrValid);
endmodule

// File: rtl/rx_tlp_splitter.sv
module rx_tlp_splitter
  import rx_split_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [BUSW-1:0] inData,
  input  logic            inValid,
  output logic            inReady,
  input  logic            inSop,
  input  logic            inEop,
  input  logic [EMPW-1:0] inEmpty,
  output logic [BUSW-1:0] outData,
  output logic            outValid,
  input  logic            outReady,
  output logic            outSop,
  output logic            outEop,
  output logic [CNTW-1:0] outCount,
  output logic            hdrValid,
  output logic [HDRW-1:0] hdrData,
  output logic            hdrFourDw,
  output logic            hdrHasData,
  output logic [LENW-1:0] hdrLength
);
  ctrlT      ctrl;
  hdrFieldsT hdrF;

  rx_split_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inEmpty(inEmpty), .hdrF(hdrF), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .outSop(outSop), .outEop(outEop), .outCount(outCount),
    .ctrl(ctrl)
  );

  rx_split_datapath uData (
    .clk(clk), .rstN(rstN), .inData(inData), .ctrl(ctrl), .outValid(outValid),
    .outReady(outReady), .hdrF(hdrF), .outData(outData), .hdrValid(hdrValid),
    .hdrData(hdrData), .hdrFourDw(hdrFourDw), .hdrHasData(hdrHasData),
    .hdrLength(hdrLength)
  );
endmodule

// File: tb/rx_tlp_splitter_test.sv
module rx_tlp_splitter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rstN;
  logic [255:0] inData;
  logic         inValid, inReady, inSop, inEop;
  logic [1:0]   inEmpty;
  logic [255:0] outData;
  logic         outValid, outReady, outSop, outEop;
  logic [3:0]   outCount;
  logic         hdrValid, hdrFourDw, hdrHasData;
  logic [127:0] hdrData;
  logic [9:0]   hdrLength;

  rx_tlp_splitter uut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .inSop(inSop), .inEop(inEop), .inEmpty(inEmpty), .outData(outData),
    .outValid(outValid), .outReady(outReady), .outSop(outSop), .outEop(outEop),
    .outCount(outCount), .hdrValid(hdrValid), .hdrData(hdrData),
    .hdrFourDw(hdrFourDw), .hdrHasData(hdrHasData), .hdrLength(hdrLength)
  );

  typedef struct { logic [31:0] d; bit first; bit last; } expDwT;
  typedef struct { logic [127:0] h; bit four; bit has; logic [9:0] len; } expHdrT;
  expDwT  expQ[$];
  expHdrT hdrQ[$];

  int checks = 0;
  int errors = 0;
  bit bpOn = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit holdPend = 0;
  logic [255:0] holdData;
  logic [5:0] holdCtl;
  int pktId = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkBeat();
    int expCnt = 0;
    bit expEop = 0;
    bit ok;
    logic [31:0] badA = '0, badE = '0;
    if (expQ.size() == 0) begin
      chk(0, "R5 R10", "output beat with no payload expected", 128'(outCount), 0);
      return;
    end
    for (int i = 0; i < 8 && i < expQ.size(); i++) begin
      expCnt++;
      if (expQ[i].last) begin expEop = 1; break; end
    end
    ok = (int'(outCount) == expCnt) && (outEop == expEop) && (outSop == expQ[0].first);
    for (int i = 0; i < expCnt; i++)
      if (outData[i*32 +: 32] !== expQ[i].d) begin
        if (ok) begin badA = outData[i*32 +: 32]; badE = expQ[i].d; end
        ok = 0;
      end
    // R1 R3 R4 R5 R6 R7 R8: lane placement, count, start and end flags
    chk(ok, "R1 R3 R4 R5 R6 R7 R8", "payload beat {cnt,sop,eop,dword}",
        {outCount, 3'b0, outSop, 3'b0, outEop, badA},
        {4'(expCnt), 3'b0, expQ[0].first, 3'b0, expEop, badE});
    for (int i = 0; i < expCnt; i++) void'(expQ.pop_front());
  endtask

  task automatic checkHdr();
    expHdrT e;
    if (hdrQ.size() == 0) begin
      chk(0, "R2", "unexpected header strobe", hdrData, 0);
      return;
    end
    e = hdrQ.pop_front();
    chk(hdrData == e.h && hdrFourDw == e.four && hdrHasData == e.has && hdrLength == e.len,
        "R2", "header sideband", {hdrData[115:0], hdrFourDw, hdrHasData, hdrLength},
        {e.h[115:0], e.four, e.has, e.len});
  endtask

  // Monitor: picks outReady for the next edge, then scores what will transfer.
  always @(negedge clk) begin
    if (!rstN) begin
      outReady = 1'b1;
      holdPend = 0;
    end else begin
      if (holdPend)
        chk(outValid && outData == holdData && {outCount, outSop, outEop} == holdCtl,
            "R9", "stalled output changed", {outValid, outCount, outData[122:0]},
            {1'b1, holdCtl[5:2], holdData[122:0]});
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = bpOn ? (lfsr[0] | lfsr[4]) : 1'b1;
      if (outValid && outReady) checkBeat();
      holdPend = outValid && !outReady;
      holdData = outData;
      holdCtl  = {outCount, outSop, outEop};
      if (hdrValid) checkHdr();
    end
  end

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 0; inSop = 0; inEop = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic sendPkt(input bit four, input bit has, input bit unal, input int len);
    logic [31:0] s[$];
    logic [9:0]  lenF;
    int skip, nb;
    expHdrT eh;
    pktId++;
    lenF = 10'(len);
    s.push_back({1'b0, has, four, 11'h0, 8'(pktId), lenF});
    s.push_back(32'hA500_0000 | 32'(pktId));
    if (four) begin
      s.push_back(32'h0000_0F00 | {29'h0, ~unal, 2'b00});
      s.push_back(32'h1000_0000 | {29'h0, unal, 2'b00});
    end else begin
      s.push_back(32'h2000_0000 | {29'h0, unal, 2'b00});
    end
    skip = four ? (unal ? 5 : 4) : (unal ? 3 : 4);
    if (has) begin
      while (s.size() < skip) s.push_back(32'hDEAD_0000 | 32'(pktId));
      for (int k = 0; k < (len == 0 ? 1024 : len); k++) begin
        expDwT e;
        e.d = {16'(pktId), 16'(k)} ^ 32'h5A00_0000;
        e.first = (k == 0);
        e.last  = (k == (len == 0 ? 1024 : len) - 1);
        s.push_back(e.d);
        expQ.push_back(e);
      end
    end
    if (s.size() % 2 == 1) s.push_back(32'hFEED_0000 | 32'(pktId));
    eh.h = {s[3], s[2], s[1], s[0]};
    eh.four = four; eh.has = has; eh.len = lenF;
    hdrQ.push_back(eh);
    nb = (s.size() + 7) / 8;
    for (int b = 0; b < nb; b++) begin
      if (bpOn && ((b + pktId) % 3 == 0)) begin
        @(negedge clk);
        inValid = 0;
      end
      @(negedge clk);
      for (int l = 0; l < 8; l++) begin
        int idx = b * 8 + l;
        inData[l*32 +: 32] = (idx < s.size()) ? s[idx] : (32'hBAD0_0000 | 32'(idx));
      end
      inValid = 1;
      inSop = (b == 0);
      inEop = (b == nb - 1);
      inEmpty = (b == nb - 1) ? 2'((nb * 8 - s.size()) / 2) : 2'b11;
      #1;
      while (!inReady) begin
        @(negedge clk);
        #1;
      end
    end
  endtask

  task automatic finish();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "R1", "watchdog expired", 0, 0);
    finish();
  end

  initial begin
    rstN = 0; inValid = 0; inSop = 0; inEop = 0; inEmpty = 0; inData = '0;
    repeat (3) @(negedge clk);
    chk(!outValid && !hdrValid, "R11", "reset outputs", {outValid, hdrValid}, 0);
    rstN = 1;
    @(negedge clk); #1;
    chk(inReady && !outValid, "R11", "ready after reset", {inReady, outValid}, 2'b10);

    sendPkt(0, 1, 0, 1);   // R3 aligned
    sendPkt(0, 1, 1, 5);   // R3 unaligned
    sendPkt(1, 1, 0, 4);   // R4 aligned
    sendPkt(1, 1, 1, 3);   // R4 unaligned
    sendPkt(0, 1, 1, 13);  // R8 flush beat
    sendPkt(1, 1, 1, 16);
    sendPkt(0, 1, 0, 17);  // R7 trailing pad
    sendPkt(1, 1, 0, 30);
    sendPkt(0, 1, 1, 8);   // exact fill
    idle(20);
    chk(expQ.size() == 0 && !outValid, "R8", "payload drained after flush",
        128'(expQ.size()), 0);

    sendPkt(0, 0, 0, 0);   // R10
    sendPkt(1, 0, 1, 0);   // R10
    idle(10);
    chk(expQ.size() == 0 && hdrQ.size() == 0 && !outValid, "R10",
        "no data beat for header-only packets", {hdrQ.size(), outValid}, 0);

    bpOn = 1;
    for (int i = 0; i < 40; i++)
      sendPkt(i % 2 == 1, (i % 5) != 4, ((i / 2) % 2) == 1, 1 + (i * 7) % 29);
    sendPkt(1, 1, 1, 0);   // R2 length field 0 means 1024
    sendPkt(0, 1, 1, 2);
    idle(2);
    for (int t = 0; t < 4000 && (expQ.size() != 0 || hdrQ.size() != 0); t++)
      @(negedge clk);
    chk(expQ.size() == 0 && hdrQ.size() == 0, "R9", "all dwords and headers delivered",
        {expQ.size(), hdrQ.size()}, 0);
    idle(5);
    chk(!outValid, "R9", "no duplicate beat after drain", 128'(outValid), 0);
    finish();
  end
endmodule